// File: doc/BRIEF.md
# Multiplicative boost frequency tracker

This block keeps a boost frequency, in kHz, that a memory-clock governor adds on top of its demand-based estimate. An activity monitor raises an "up" pulse when traffic has stayed above its upper threshold for a while, and a "down" pulse when traffic has stayed below its lower threshold. On up, the boost is scaled by a percentage coefficient and a fixed step is added. The result saturates at the maximum frequency. On down, the boost is scaled by a second coefficient. It collapses to zero once it drops under half the step.

The block also drives two enable bits back to the monitor. One allows further consecutive-above events and the other allows consecutive-below events. An enable is withdrawn once the boost sits at the limit that its event would push toward. An optional average-count threshold can override the below enable. The division by one hundred runs on a bit-serial divider, so each update takes a fixed number of cycles. A one-cycle done pulse marks the cycle in which the new value appears.

Top module: `boost_tracker`

## Requirements
- R1: On an up event, the new boost is floor(old × up_pct / 100) + STEP, where STEP is 16000 by default, unless R2 applies.
- R2: If the up result is greater than or equal to max_khz, the boost becomes max_khz and above_en drops to 0.
- R3: On a down event, the new boost is floor(old × down_pct / 100). If that value is below STEP/2 (8000), the boost becomes 0 and below_en drops to 0.
- R4: Every accepted event first sets both above_en and below_en to 1. Only then may R2, R3 or R6 clear one of them.
- R5: When up_evt and down_evt are both high in the cycle an event is accepted, only the up update is performed.
- R6: When avg_floor is nonzero, an avg_count at or above avg_floor forces below_en to 1 after the update. Otherwise a resulting boost of 0 forces below_en to 0. When avg_floor is 0, this rule has no effect.
- R7: Each accepted event produces exactly one done pulse, one cycle wide, within 64 cycles. boost_khz, above_en and below_en change only in the cycle where done is high.
- R8: Events that arrive while an update is in progress are ignored. The result equals that of the single accepted event.
- R9: Synchronous reset gives boost_khz = 0, above_en = 1, below_en = 1 and done = 0.
- R10: A down result above max_khz (possible when down_pct exceeds 100) is limited to max_khz, and the enables are left as R4 sets them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_evt | input | 1 | Consecutive-above event pulse |
| down_evt | input | 1 | Consecutive-below event pulse |
| up_pct | input | PCT_W | Up scaling coefficient in percent |
| down_pct | input | PCT_W | Down scaling coefficient in percent |
| max_khz | input | FREQ_W | Saturation ceiling in kHz |
| avg_count | input | AVG_W | Current average activity count |
| avg_floor | input | AVG_W | Average-dependency threshold, 0 disables |
| boost_khz | output | FREQ_W | Current boost frequency in kHz |
| above_en | output | 1 | Enable for consecutive-above events |
| below_en | output | 1 | Enable for consecutive-below events |
| done | output | 1 | One-cycle pulse when an update lands |

## Verification
The main function is driven through climbing ramps of up events followed by decaying runs of down events. These use three coefficient pairs and three ceilings, including the full 24-bit range. This separates the floor-of-product arithmetic from the saturation point and from the half-step snap to zero. Dedicated sequences press both events at once, so up priority can be told apart from down. They also inject a stray event mid-update to show it leaves no trace, and use a down coefficient above 100 to reach the ceiling from below. Average-threshold runs toggle avg_count around a nonzero floor while the boost is at zero and while it is nonzero. This distinguishes the forced-on case from the forced-off case and from the inactive zero floor.

// File: rtl/boost_trk_pkg.sv
package boost_trk_pkg;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } boost_dir_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_DIVIDE = 1'b1
    } trk_state_e;

    typedef struct packed {
        logic above;
        logic below;
    } mon_en_t;

    localparam mon_en_t EN_BOTH = '{above: 1'b1, below: 1'b1};

    // up wins when both pulses are present
    function automatic boost_dir_e pick_dir(input logic up, input logic down);
        if (up)
            return DIR_UP;
        else if (down)
            return DIR_DOWN;
        else
            return DIR_DOWN;
    endfunction

endpackage

// File: rtl/boost_div_const.sv
module boost_div_const #(
    parameter int DVD_W   = 34,
    parameter int DIVISOR = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DVD_W-1:0] dividend,
    output logic [DVD_W-1:0] quotient,
    output logic             valid,
    output logic             busy
);
    localparam int REM_W = $clog2(DIVISOR);
    localparam int CNT_W = $clog2(DVD_W + 1);
    localparam int CHK_W = DVD_W + REM_W + 1;
    localparam logic [REM_W:0] DIV_K = (REM_W+1)'(DIVISOR);

    logic [DVD_W-1:0] dvd_q, quo_q, ref_q;
    logic [REM_W-1:0] rem_q, rem_n;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q, valid_q;
    logic [REM_W:0]   trial, diff;
    logic             ge;

    // one restoring step: bring down the next dividend bit
    always_comb begin
        trial = {rem_q, dvd_q[DVD_W-1]};
        diff  = trial - DIV_K;
        ge    = (trial >= DIV_K);
        rem_n = ge ? diff[REM_W-1:0] : trial[REM_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dvd_q   <= '0;
            quo_q   <= '0;
            ref_q   <= '0;
            rem_q   <= '0;
            cnt_q   <= '0;
            busy_q  <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (start) begin
                dvd_q  <= dividend;
                ref_q  <= dividend;
                quo_q  <= '0;
                rem_q  <= '0;
                cnt_q  <= CNT_W'(DVD_W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                dvd_q <= {dvd_q[DVD_W-2:0], 1'b0};
                quo_q <= {quo_q[DVD_W-2:0], ge};
                rem_q <= rem_n;
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    busy_q  <= 1'b0;
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign quotient = quo_q;
    assign valid    = valid_q;
    assign busy     = busy_q;

    // quotient and remainder reconstruct the captured dividend (R1)
    p_div_exact_r1: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> ((CHK_W'(quo_q) * CHK_W'(DIVISOR) + CHK_W'(rem_q)) == CHK_W'(ref_q))
                    && (CHK_W'(rem_q) < CHK_W'(DIVISOR)));

    // a new operation is never launched on top of a running one (R8)
    p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy_q);

endmodule

// File: rtl/boost_limit.sv
module boost_limit
    import boost_trk_pkg::*;
#(
    parameter int FREQ_W = 24,
    parameter int PROD_W = 34,
    parameter int AVG_W  = 32,
    parameter int STEP   = 16000
) (
    input  boost_dir_e        dir,
    input  logic [PROD_W-1:0] scaled,
    input  logic [FREQ_W-1:0] max_khz,
    input  logic [AVG_W-1:0]  avg_count,
    input  logic [AVG_W-1:0]  avg_floor,
    output logic [FREQ_W-1:0] next_boost,
    output mon_en_t           next_en
);
    localparam int SUM_W = PROD_W + 1;
    localparam logic [SUM_W-1:0] STEP_K = SUM_W'(STEP);
    localparam logic [SUM_W-1:0] HALF_K = SUM_W'(STEP / 2);

    logic [SUM_W-1:0] sum_up, wide_dn, wide_max;

    always_comb begin
        sum_up   = {1'b0, scaled} + STEP_K;
        wide_dn  = {1'b0, scaled};
        wide_max = SUM_W'(max_khz);
        next_en  = EN_BOTH;
        if (dir == DIR_UP) begin
            if (sum_up >= wide_max) begin
                next_boost    = max_khz;
                next_en.above = 1'b0;
            end else begin
                next_boost = sum_up[FREQ_W-1:0];
            end
        end else begin
            if (wide_dn < HALF_K) begin
                next_boost    = '0;
                next_en.below = 1'b0;
            end else if (wide_dn > wide_max) begin
                next_boost = max_khz;
            end else begin
                next_boost = wide_dn[FREQ_W-1:0];
            end
        end
        // average-dependency override of the below enable
        if (avg_floor != '0) begin
            if (avg_count >= avg_floor)
                next_en.below = 1'b1;
            else if (next_boost == '0)
                next_en.below = 1'b0;
        end
    end

endmodule

// File: rtl/boost_tracker.sv
module boost_tracker
    import boost_trk_pkg::*;
#(
    parameter int FREQ_W  = 24,
    parameter int PCT_W   = 10,
    parameter int AVG_W   = 32,
    parameter int STEP    = 16000,
    parameter int DIVISOR = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_evt,
    input  logic              down_evt,
    input  logic [PCT_W-1:0]  up_pct,
    input  logic [PCT_W-1:0]  down_pct,
    input  logic [FREQ_W-1:0] max_khz,
    input  logic [AVG_W-1:0]  avg_count,
    input  logic [AVG_W-1:0]  avg_floor,
    output logic [FREQ_W-1:0] boost_khz,
    output logic              above_en,
    output logic              below_en,
    output logic              done
);
    localparam int PROD_W = FREQ_W + PCT_W;
    localparam logic [FREQ_W-1:0] HALF_K = FREQ_W'(STEP / 2);

    trk_state_e        state_q;
    boost_dir_e        dir_q, dir_sel;
    logic [FREQ_W-1:0] boost_q, next_boost;
    mon_en_t           en_q, next_en;
    logic              done_q;
    logic              evt_any, div_start, div_valid, div_busy;
    logic [PCT_W-1:0]  coeff_sel;
    logic [PROD_W-1:0] product, quotient;

    always_comb begin
        evt_any   = up_evt | down_evt;
        dir_sel   = pick_dir(up_evt, down_evt);
        coeff_sel = (dir_sel == DIR_UP) ? up_pct : down_pct;
        product   = PROD_W'(boost_q) * PROD_W'(coeff_sel);
        div_start = (state_q == ST_IDLE) && evt_any;
    end

    boost_div_const #(
        .DVD_W   (PROD_W),
        .DIVISOR (DIVISOR)
    ) i_div (
        .clk      (clk),
        .rst      (rst),
        .start    (div_start),
        .dividend (product),
        .quotient (quotient),
        .valid    (div_valid),
        .busy     (div_busy)
    );

    boost_limit #(
        .FREQ_W (FREQ_W),
        .PROD_W (PROD_W),
        .AVG_W  (AVG_W),
        .STEP   (STEP)
    ) i_limit (
        .dir        (dir_q),
        .scaled     (quotient),
        .max_khz    (max_khz),
        .avg_count  (avg_count),
        .avg_floor  (avg_floor),
        .next_boost (next_boost),
        .next_en    (next_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            dir_q   <= DIR_DOWN;
            boost_q <= '0;
            en_q    <= EN_BOTH;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (evt_any) begin
                        dir_q   <= dir_sel;
                        state_q <= ST_DIVIDE;
                    end
                end
                ST_DIVIDE: begin
                    if (div_valid) begin
                        boost_q <= next_boost;
                        en_q    <= next_en;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign boost_khz = boost_q;
    assign above_en  = en_q.above;
    assign below_en  = en_q.below;
    assign done      = done_q;

    p_reset_state_r9: assert property (@(posedge clk)
        rst |=> (boost_khz == '0) && above_en && below_en && !done);

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_hold_between_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(boost_khz) |-> done);

    p_ceiling_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> (boost_khz <= max_khz));

    p_snap_gap_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> (boost_khz == '0) || (boost_khz >= HALF_K));

    p_up_keeps_below_r4: assert property (@(posedge clk) disable iff (rst)
        (done && (dir_q == DIR_UP)) |-> below_en);

    p_busy_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        div_busy |-> (state_q == ST_DIVIDE));

endmodule

// File: tb/test_boost_tracker.sv
`timescale 1ns/1ps
module test_boost_tracker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        up_evt = 1'b0;
    logic        down_evt = 1'b0;
    logic [9:0]  up_pct = '0;
    logic [9:0]  down_pct = '0;
    logic [23:0] max_khz = '0;
    logic [31:0] avg_count = '0;
    logic [31:0] avg_floor = '0;
    logic [23:0] boost_khz;
    logic        above_en, below_en, done;

    int    checks = 0;
    int    errors = 0;
    longint mb;
    bit    ma, mbl;
    longint cu, cd, mx, avg, thr;

    always #2 clk = ~clk;

    boost_tracker i_boost_tracker (
        .clk       (clk),
        .rst       (rst),
        .up_evt    (up_evt),
        .down_evt  (down_evt),
        .up_pct    (up_pct),
        .down_pct  (down_pct),
        .max_khz   (max_khz),
        .avg_count (avg_count),
        .avg_floor (avg_floor),
        .boost_khz (boost_khz),
        .above_en  (above_en),
        .below_en  (below_en),
        .done      (done)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive_cfg();
        up_pct    = cu[9:0];
        down_pct  = cd[9:0];
        max_khz   = mx[23:0];
        avg_count = avg[31:0];
        avg_floor = thr[31:0];
    endtask

    // reference behaviour of one accepted event
    task automatic model_step(input bit up, input bit dn);
        longint t;
        ma  = 1'b1;
        mbl = 1'b1;
        if (up) begin
            t = (mb * cu) / 100 + 16000;
            if (t >= mx) begin
                mb = mx;
                ma = 1'b0;
            end else mb = t;
        end else if (dn) begin
            t = (mb * cd) / 100;
            if (t < 8000) begin
                mb  = 0;
                mbl = 1'b0;
            end else if (t > mx) mb = mx;
            else mb = t;
        end
        if (thr != 0) begin
            if (avg >= thr) mbl = 1'b1;
            else if (mb == 0) mbl = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        up_evt = 1'b0;
        down_evt = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        mb = 0; ma = 1'b1; mbl = 1'b1;
        @(negedge clk);
        chk(boost_khz == 0, "R9 boost", longint'(boost_khz), 0);
        chk(above_en && below_en, "R9 enables", {above_en, below_en}, 3);
        chk(!done, "R9 done", longint'(done), 0);
    endtask

    task automatic run_event(input bit up, input bit dn, input bit poke, input string tag);
        logic [23:0] prev;
        bit stable_ok;
        int n;
        @(negedge clk);
        up_evt = up;
        down_evt = dn;
        prev = boost_khz;
        @(negedge clk);
        up_evt = 1'b0;
        down_evt = 1'b0;
        n = 0;
        stable_ok = 1'b1;
        while (!done && n < 64) begin
            // R8: a stray event while the divider is running
            if (poke && n == 3) down_evt = 1'b1;
            else down_evt = 1'b0;
            if (boost_khz != prev) stable_ok = 1'b0;
            @(negedge clk);
            n++;
        end
        down_evt = 1'b0;
        chk(done == 1'b1, {tag, " R7 done seen"}, longint'(done), 1);
        chk(stable_ok, {tag, " R7 boost held before done"}, 0, 1);
        model_step(up, dn);
        chk(longint'(boost_khz) == mb, {tag, " boost"}, longint'(boost_khz), mb);
        chk(above_en == ma, {tag, " above_en"}, longint'(above_en), longint'(ma));
        chk(below_en == mbl, {tag, " below_en"}, longint'(below_en), longint'(mbl));
        @(negedge clk);
        chk(!done, {tag, " R7 done one cycle"}, longint'(done), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        longint ups [3] = '{200, 800, 120};
        longint dns [3] = '{50, 90, 30};
        longint maxs[3] = '{500000, 1000000, 16777215};
        cu = 200; cd = 50; mx = 500000; avg = 0; thr = 0;
        drive_cfg();
        do_reset();

        // R1 R2 R3 R8: ramps over coefficient pairs and ceilings
        for (int i = 0; i < 3; i++) begin
            for (int m = 0; m < 3; m++) begin
                cu = ups[i]; cd = dns[i]; mx = maxs[m]; avg = 0; thr = 0;
                drive_cfg();
                do_reset();
                for (int k = 0; k < 20; k++)
                    run_event(1'b1, 1'b0, (k == 2), (k == 2) ? "R8 R1 up" : "R1 R2 up");
                for (int k = 0; k < 60; k++) begin
                    if (mb == 0 && k > 0) begin
                        run_event(1'b0, 1'b1, 1'b0, "R3 down at zero");
                        break;
                    end
                    run_event(1'b0, 1'b1, (k == 1), (k == 1) ? "R8 R3 down" : "R3 down");
                end
            end
        end

        // R5: both pulses together perform the up update
        cu = 200; cd = 50; mx = 500000; avg = 0; thr = 0;
        drive_cfg();
        do_reset();
        run_event(1'b1, 1'b1, 1'b0, "R5 both");
        chk(boost_khz == 24'd16000, "R5 up taken", longint'(boost_khz), 16000);
        run_event(1'b1, 1'b1, 1'b0, "R5 both again");

        // R4: clamp clears above, next down restores it
        for (int k = 0; k < 6; k++) run_event(1'b1, 1'b0, 1'b0, "R2 climb");
        chk(!above_en, "R2 above cleared at ceiling", longint'(above_en), 0);
        run_event(1'b0, 1'b1, 1'b0, "R4 down re-enables above");
        chk(above_en && below_en, "R4 both set", {above_en, below_en}, 3);

        // R10: down coefficient above 100 at the ceiling
        for (int k = 0; k < 3; k++) run_event(1'b1, 1'b0, 1'b0, "R2 refill");
        cd = 150; drive_cfg();
        run_event(1'b0, 1'b1, 1'b0, "R10 down over ceiling");
        chk(boost_khz == 24'd500000, "R10 limited", longint'(boost_khz), 500000);
        chk(above_en, "R10 above set", longint'(above_en), 1);

        // R6: average-dependency override
        cd = 50; thr = 50000; avg = 60000; drive_cfg();
        do_reset();
        run_event(1'b0, 1'b1, 1'b0, "R6 zero boost avg high");
        chk(below_en, "R6 forced on", longint'(below_en), 1);
        avg = 10000; drive_cfg();
        run_event(1'b0, 1'b1, 1'b0, "R6 zero boost avg low");
        chk(!below_en, "R6 forced off", longint'(below_en), 0);
        run_event(1'b1, 1'b0, 1'b0, "R6 nonzero boost avg low");
        chk(below_en, "R6 untouched when nonzero", longint'(below_en), 1);
        thr = 0; avg = 90000; drive_cfg();
        run_event(1'b0, 1'b1, 1'b0, "R6 floor zero inactive");
        run_event(1'b0, 1'b1, 1'b0, "R6 floor zero snap");
        chk(!below_en, "R6 zero floor no force", longint'(below_en), 0);

        // R9: reset in the middle of activity
        run_event(1'b1, 1'b0, 1'b0, "R1 pre-reset");
        do_reset();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule